// File: doc/BRIEF.md
# Peripheral Bus Access-Phase Monitor

This block sits beside one manager-to-subordinate link of an APB bus and only watches it. On every rising clock edge it samples the select, enable, direction, address, write data, ready, read data and error lines. From these samples it finds the single edge on which each transfer completes and counts the wait states in front of it. It records the read data and error status seen on that edge, and raises a sticky flag for each kind of handshake misbehaviour it sees. It drives nothing on the bus.

A transfer completes on the one edge where select, enable and ready are all sampled high. The wait count is the number of edges, directly before that edge, on which select and enable were high and ready was low. Read data and error values on wait edges never reach the outputs. There are four violation flags. The first marks enable falling while select stays high and a transfer is still waiting. The second marks address, direction or write data moving during the access phase. The third marks enable appearing without a setup edge before it. The fourth marks enable high while select is low.

Top module: `apb_access_monitor`

## Requirements
- R1: `xfer_done` is high for exactly the one cycle after each edge that samples `bus_sel`, `bus_enable` and `bus_ready` all high, and is low otherwise.
- R2: `wait_count` takes its new value in the same cycle `xfer_done` is high. The new value is the number of consecutive edges, just before the completion edge, that sampled `bus_sel`=1, `bus_enable`=1 and `bus_ready`=0. It holds between completions.
- R3: The wait count saturates at 2^WAIT_W-1 and does not wrap.
- R4: On a completion edge, `last_err` takes `bus_err`. `last_rdata` takes `bus_rdata` only when `bus_write`=0; a write completion leaves it unchanged. Values on wait or idle edges have no effect on either output.
- R5: `err_enable_drop` is set by an edge that samples `bus_sel`=1 and `bus_enable`=0 when the previous edge was a waiting access edge (select and enable high, ready low).
- R6: `err_moved` is set by an access edge (select and enable high) whose `bus_addr`, `bus_write` or `bus_wdata` differs from the previous edge, when that previous edge was a setup edge or a waiting access edge.
- R7: `err_no_setup` is set by an access edge when the previous edge was neither a setup edge (select high, enable low) nor a waiting access edge.
- R8: `err_enable_unsel` is set by any edge that samples `bus_enable`=1 while `bus_sel`=0.
- R9: Reset (`rst_n`=0, synchronous) clears every output to 0. Violation flags stay set until the next reset, and clean transfers never set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Subordinate select |
| bus_enable | input | 1 | Access-phase enable |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Transfer address |
| bus_wdata | input | DATA_W | Write data |
| bus_ready | input | 1 | Subordinate ready |
| bus_rdata | input | DATA_W | Read data from subordinate |
| bus_err | input | 1 | Subordinate error status |
| err_enable_drop | output | 1 | Sticky: enable fell during a waiting access |
| err_moved | output | 1 | Sticky: held signals changed during access |
| err_no_setup | output | 1 | Sticky: access without setup |
| err_enable_unsel | output | 1 | Sticky: enable high with select low |
| wait_count | output | WAIT_W | Wait states of the last transfer |
| xfer_done | output | 1 | One-cycle completion pulse |
| last_rdata | output | DATA_W | Read data of the last completed read |
| last_err | output | 1 | Error status of the last completed transfer |

## Verification
The bench builds the monitor with WAIT_W=3, ADDR_W=8 and DATA_W=16. A three-bit counter brings saturation within reach: a transfer with nine wait states must report 7, and one with exactly seven waits sits on the boundary. The narrow buses keep the directed patterns short. They are still wide enough that a single changed address bit or data bit during a wait must trip the movement flag. Garbage read data and a high error line are driven on every wait edge, so any capture outside the completion edge shows up at the outputs.

// File: rtl/apb_access_monitor.sv
module apb_access_monitor #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic              err_enable_drop,
  output logic              err_moved,
  output logic              err_no_setup,
  output logic              err_enable_unsel,
  output logic [WAIT_W-1:0] wait_count,
  output logic              xfer_done,
  output logic [DATA_W-1:0] last_rdata,
  output logic              last_err
);

  localparam logic [WAIT_W-1:0] WAIT_MAX = {WAIT_W{1'b1}};

  logic              was_setup, waiting;
  logic [WAIT_W-1:0] wcnt;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;
  logic              p_write;

  wire access = bus_sel & bus_enable;
  wire finish = access & bus_ready;
  wire stall  = access & ~bus_ready;
  wire moved  = (bus_addr != p_addr) | (bus_write != p_write) | (bus_wdata != p_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_setup        <= 1'b0;
      waiting          <= 1'b0;
      wcnt             <= '0;
      p_addr           <= '0;
      p_wdata          <= '0;
      p_write          <= 1'b0;
      wait_count       <= '0;
      xfer_done        <= 1'b0;
      last_rdata       <= '0;
      last_err         <= 1'b0;
      err_enable_drop  <= 1'b0;
      err_moved        <= 1'b0;
      err_no_setup     <= 1'b0;
      err_enable_unsel <= 1'b0;
    end else begin
      was_setup <= bus_sel & ~bus_enable;
      waiting   <= stall;
      p_addr    <= bus_addr;
      p_wdata   <= bus_wdata;
      p_write   <= bus_write;

      if (stall) wcnt <= (wcnt == WAIT_MAX) ? wcnt : wcnt + 1'b1;
      else       wcnt <= '0;

      xfer_done <= finish;
      if (finish) begin
        wait_count <= wcnt;
        last_err   <= bus_err;
        if (!bus_write) last_rdata <= bus_rdata;
      end

      if (bus_sel & ~bus_enable & waiting)       err_enable_drop  <= 1'b1;
      if (access & (was_setup | waiting) & moved) err_moved       <= 1'b1;
      if (access & ~was_setup & ~waiting)        err_no_setup     <= 1'b1;
      if (~bus_sel & bus_enable)                 err_enable_unsel <= 1'b1;
    end
  end

  wire [3:0] flags = {err_enable_drop, err_moved, err_no_setup, err_enable_unsel};

  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags)) == $past(flags)));

  a_r1_done_follows_completion: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(bus_sel & bus_enable & bus_ready));

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && wcnt == WAIT_MAX) |=> (wcnt == WAIT_MAX));

  a_r4_capture_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |-> ($stable(last_rdata) && $stable(last_err) && $stable(wait_count)));

  a_r8_unsel_enable_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && bus_enable) |=> err_enable_unsel);

endmodule

// File: tb/sim_apb_access_monitor.sv
module sim_apb_access_monitor;
  localparam int AW = 8, DW = 16, WW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, en = 0, wr = 0, rdy = 0, berr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata = '0;
  logic f_drop, f_move, f_nosetup, f_unsel, done, lerr;
  logic [WW-1:0] wcount;
  logic [DW-1:0] lrdata;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  apb_access_monitor #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_enable(en), .bus_write(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_ready(rdy), .bus_rdata(rdata),
    .bus_err(berr), .err_enable_drop(f_drop), .err_moved(f_move),
    .err_no_setup(f_nosetup), .err_enable_unsel(f_unsel), .wait_count(wcount),
    .xfer_done(done), .last_rdata(lrdata), .last_err(lerr));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    sel = 0; en = 0; rdy = 0; berr = 0; rdata = 16'hdead;
  endtask

  task automatic do_reset();
    @(negedge clk); idle_bus(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  // full clean transfer; checks completion cycle outputs
  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int nwait, input logic [DW-1:0] rd, input logic e,
                      input logic [WW-1:0] exp_wait, input logic [DW-1:0] exp_rd);
    sel = 1; en = 0; wr = w; addr = a; wdata = d; rdy = 0;
    @(negedge clk);
    en = 1; rdata = ~rd; berr = 1;
    repeat (nwait) begin
      @(negedge clk);
      check("R1 no pulse while waiting", done, 0);
    end
    rdy = 1; rdata = rd; berr = e;
    @(negedge clk);
    idle_bus();
    check("R1 done pulse", done, 1);
    check("R2/R3 wait count", wcount, exp_wait);
    check("R4 last_rdata", lrdata, exp_rd);
    check("R4 last_err", lerr, e);
    @(negedge clk);
    check("R1 pulse one cycle", done, 0);
    check("R2 count held", wcount, exp_wait);
  endtask

  task automatic t_reset();
    check("R9 reset flags", {f_drop, f_move, f_nosetup, f_unsel}, 0);
    check("R9 reset done", done, 0);
    check("R9 reset count", wcount, 0);
    check("R9 reset rdata", lrdata, 0);
    check("R9 reset err", lerr, 0);
  endtask

  task automatic t_clean();
    xfer(0, 8'h10, 16'h0, 0, 16'h1234, 0, 0, 16'h1234);
    xfer(0, 8'h11, 16'h0, 2, 16'h5678, 1, 2, 16'h5678);
    xfer(1, 8'h12, 16'haaaa, 1, 16'h9999, 0, 1, 16'h5678); // R4 write keeps rdata
    xfer(0, 8'h13, 16'h0, 7, 16'h0777, 0, 7, 16'h0777);    // R3 boundary
    xfer(0, 8'h14, 16'h0, 9, 16'h0999, 1, 7, 16'h0999);    // R3 saturate
    check("R9 clean transfers leave flags clear", {f_drop, f_move, f_nosetup, f_unsel}, 0);
  endtask

  task automatic t_drop();
    do_reset();
    sel = 1; en = 0; addr = 8'h20; @(negedge clk);
    en = 1; rdy = 0; @(negedge clk);
    en = 0; @(negedge clk);
    idle_bus(); @(negedge clk);
    check("R5 enable drop flag", f_drop, 1);
    check("R5 other flags", {f_move, f_nosetup, f_unsel}, 0);
    xfer(0, 8'h21, 16'h0, 1, 16'h4242, 0, 1, 16'h4242);
    check("R9 drop flag sticky", f_drop, 1);
  endtask

  task automatic t_move();
    do_reset();
    sel = 1; en = 0; wr = 1; addr = 8'h30; wdata = 16'h00f0; @(negedge clk);
    en = 1; rdy = 0; @(negedge clk);
    check("R6 no flag before change", f_move, 0);
    wdata = 16'h00f1; @(negedge clk);
    idle_bus(); @(negedge clk);
    check("R6 data move flag", f_move, 1);
    do_reset();
    sel = 1; en = 0; wr = 0; addr = 8'h30; @(negedge clk);
    en = 1; addr = 8'h31; rdy = 1; @(negedge clk);
    idle_bus(); @(negedge clk);
    check("R6 address move setup-to-access", f_move, 1);
    check("R6 completion still counted", lrdata, 16'hdead);
  endtask

  task automatic t_nosetup();
    do_reset();
    sel = 1; en = 1; rdy = 1; wr = 0; rdata = 16'h0bad; @(negedge clk);
    idle_bus();
    check("R7 completion pulses anyway", done, 1);
    @(negedge clk);
    check("R7 no-setup flag", f_nosetup, 1);
    check("R7 other flags", {f_drop, f_move, f_unsel}, 0);
  endtask

  task automatic t_unsel();
    do_reset();
    sel = 0; en = 1; rdy = 1; @(negedge clk);
    idle_bus();
    check("R8 no completion without select", done, 0);
    @(negedge clk);
    check("R8 enable-unselected flag", f_unsel, 1);
    check("R8 other flags", {f_drop, f_move, f_nosetup}, 0);
    do_reset();
    check("R9 reset clears sticky flag", f_unsel, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    idle_bus();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_drop();
    t_move();
    t_nosetup();
    t_unsel();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule